// File: doc/BRIEF.md
# Header sub-port address extractor

This block watches the bytes of a packet header as they stream past and pulls a 3-bit sub-port address out of one of them. The header carries a user prepend, the cell header proper and user-defined bytes, and is at most 18 bytes long. A 5-bit byte selector names the header byte that carries the address. An 8-bit position mask names the three bit positions within that byte that hold the address bits. Those three bits may sit anywhere in the byte. They are gathered into a dense 3-bit value, keeping their order, so that the highest marked position becomes the address MSB.

A header begins with the byte that arrives together with the start strobe. That byte is number 0, and each further accepted byte takes the next number. One clock after the selected byte is accepted, the address appears on the output with a one-cycle valid strobe. Only one address is produced per header. An error flag shows whether the present configuration can be used. No address is produced when the configuration is bad, or when a new header starts before the selected byte has arrived.

Top module: `subport_addr_extract`

## Requirements
- R1: While reset is held and after its release, before any byte is accepted, `sp_addr`, `sp_addr_vld` and `cfg_bad` are all 0.
- R2: The byte accepted with `hdr_sof` and `in_vld` both high is header byte 0. Each later accepted byte of that header takes the next number. Cycles with `in_vld` low are not counted.
- R3: `sp_addr_vld` is high for exactly the one cycle after the clock edge that accepts the header byte whose number equals `cfg_byte_idx`. This happens at most once per header.
- R4: If the set bits of `cfg_pos_mask` are at positions p2 > p1 > p0, then `sp_addr` = {byte[p2], byte[p1], byte[p0]}. With the reset-style mask 0x07 this gives byte[2:0].
- R5: In the cycle after a clock edge, `cfg_bad` is 1 if, at that edge, `cfg_pos_mask` did not have exactly three bits set or `cfg_byte_idx` was 18 or more. Otherwise it is 0.
- R6: If the configuration is invalid in the sense of R5 when the selected byte is accepted, no address strobe is produced for that header.
- R7: If a new `hdr_sof` arrives before the selected byte of the current header, the current header produces no strobe, and numbering restarts at 0 with the new header.
- R8: `sp_addr` keeps its last value in every cycle in which `sp_addr_vld` is low.
- R9: Bytes accepted before the first `hdr_sof` after reset belong to no header and never cause a strobe.
- R10: `hdr_sof` has no effect when `in_vld` is low. It neither starts a header nor restarts numbering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | A header byte is present on `in_byte` |
| hdr_sof | input | 1 | Marks the present byte as header byte 0 |
| in_byte | input | 8 | Header byte |
| cfg_byte_idx | input | 5 | Number of the header byte that carries the address |
| cfg_pos_mask | input | 8 | Bit positions of the address within the selected byte |
| sp_addr | output | 3 | Gathered sub-port address |
| sp_addr_vld | output | 1 | One-cycle strobe: `sp_addr` is new |
| cfg_bad | output | 1 | Configuration unusable (mask weight not 3 or index too large) |

## Verification
The hardest case to reach is a selected byte that sits late in the header, near index 17, while the stream has idle gaps, a bare start strobe without data, and restarts that end a header early. In that situation the numbering must survive gaps and ignore the bare strobe, yet restart on a real start. Random headers of 1 to 20 bytes are used, with random idle cycles and random bare strobes, so that the selected byte is sometimes reached and sometimes cut off. Directed sequences pin down index 17, index 18, a four-bit mask and a scattered mask.

// File: rtl/subport_addr_pkg.sv
// Package: shared sizes for the sub-port address extractor.
// Assumes: a header holds at most HDR_BYTES bytes and the address is
// SP_W bits taken from one DATA_W-bit byte.
package subport_addr_pkg;
    localparam int HDR_BYTES = 18;
    localparam int DATA_W    = 8;
    localparam int SP_W      = 3;
    localparam int IDX_W     = 5;
endpackage

// File: rtl/hdr_byte_tracker.sv
// Module: hdr_byte_tracker
// Numbers the bytes of the current header and tells whether the present
// byte may still yield an address.
// Assumes: hdr_sof only counts when in_vld is high; the count saturates at
// MAX_BYTES, which is never a legal selector value.
module hdr_byte_tracker #(
    parameter int MAX_BYTES = 18,
    parameter int IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             hdr_sof,
    input  logic             fire,
    output logic [IDX_W-1:0] cur_idx,
    output logic             eligible
);
    localparam logic [IDX_W:0] SAT = (IDX_W+1)'(MAX_BYTES);

    logic [IDX_W-1:0] cnt_q;
    logic             armed_q;
    logic             done_q;
    logic             sof_acc;
    logic [IDX_W:0]   nxt_cnt;

    // Number of the present byte: a start byte is always 0.
    assign sof_acc  = in_vld && hdr_sof;
    assign cur_idx  = sof_acc ? '0 : cnt_q;
    // A byte is eligible if it belongs to a header that has not yet produced an address.
    assign eligible = in_vld && (sof_acc || (armed_q && !done_q));

    // Next count, held at the saturation value.
    always_comb begin
        nxt_cnt = {1'b0, cur_idx} + 1'b1;
        if (nxt_cnt > SAT) nxt_cnt = SAT;
    end

    // Count, header-open flag and served flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (in_vld) begin
            cnt_q   <= nxt_cnt[IDX_W-1:0];
            armed_q <= armed_q || hdr_sof;
            done_q  <= fire || (done_q && !hdr_sof);
        end
    end
endmodule

// File: rtl/sp_cfg_check.sv
// Module: sp_cfg_check
// Tells whether the selector and mask form a usable configuration.
// Assumes: usable means exactly SP_W mask bits set and selector < MAX_BYTES.
module sp_cfg_check #(
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 5,
    parameter int SP_W      = 3,
    parameter int MAX_BYTES = 18
) (
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [DATA_W-1:0] pos_mask,
    output logic              cfg_ok
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] weight;

    // Number of marked positions in the mask.
    always_comb begin
        weight = '0;
        for (int i = 0; i < DATA_W; i++) begin
            weight = weight + CNT_W'(pos_mask[i]);
        end
    end

    // Usable when the weight matches the address width and the index is in range.
    assign cfg_ok = (weight == CNT_W'(SP_W)) &&
                    ({1'b0, byte_idx} < (IDX_W+1)'(MAX_BYTES));
endmodule

// File: rtl/sp_bit_gather.sv
// Module: sp_bit_gather
// Packs the marked bits of a byte into a dense field: the k-th lowest
// marked position feeds output bit k.
// Assumes: marks beyond the SP_W-th are dropped (the configuration check
// flags that case).
module sp_bit_gather #(
    parameter int DATA_W = 8,
    parameter int SP_W   = 3
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] pos_mask,
    output logic [SP_W-1:0]   packed_bits
);
    // Number of marked positions strictly below position pos.
    function automatic int marks_below(input logic [DATA_W-1:0] m, input int pos);
        int n;
        n = 0;
        for (int j = 0; j < DATA_W; j++) begin
            if (j < pos && m[j]) n++;
        end
        return n;
    endfunction

    for (genvar gk = 0; gk < SP_W; gk++) begin : g_out
        logic [DATA_W-1:0] pick;
        for (genvar gi = 0; gi < DATA_W; gi++) begin : g_pos
            // Position gi feeds output bit gk when it is the gk-th marked position.
            assign pick[gi] = pos_mask[gi] && (marks_below(pos_mask, gi) == gk);
        end
        // Output bit gk: the data bit at its chosen position.
        assign packed_bits[gk] = |(pick & data);
    end
endmodule

// File: rtl/subport_addr_extract.sv
// Module: subport_addr_extract (top)
// Extracts a SP_W-bit sub-port address from one byte of a streamed header,
// strobing it one cycle after the selected byte is accepted.
// Assumes: the configuration is held steady within a header; a header is
// opened by in_vld together with hdr_sof.
module subport_addr_extract
    import subport_addr_pkg::*;
#(
    parameter int MAX_BYTES = HDR_BYTES,
    parameter int BYTE_W    = DATA_W,
    parameter int ADDR_W    = SP_W,
    parameter int SEL_W     = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              hdr_sof,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [SEL_W-1:0]  cfg_byte_idx,
    input  logic [BYTE_W-1:0] cfg_pos_mask,
    output logic [ADDR_W-1:0] sp_addr,
    output logic              sp_addr_vld,
    output logic              cfg_bad
);
    logic [SEL_W-1:0]  cur_idx;
    logic              eligible;
    logic              cfg_ok;
    logic              fire;
    logic [ADDR_W-1:0] gathered;

    hdr_byte_tracker #(.MAX_BYTES(MAX_BYTES), .IDX_W(SEL_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .hdr_sof  (hdr_sof),
        .fire     (fire),
        .cur_idx  (cur_idx),
        .eligible (eligible)
    );

    sp_cfg_check #(.DATA_W(BYTE_W), .IDX_W(SEL_W), .SP_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_cfg (
        .byte_idx (cfg_byte_idx),
        .pos_mask (cfg_pos_mask),
        .cfg_ok   (cfg_ok)
    );

    sp_bit_gather #(.DATA_W(BYTE_W), .SP_W(ADDR_W)) u_gather (
        .data        (in_byte),
        .pos_mask    (cfg_pos_mask),
        .packed_bits (gathered)
    );

    // Capture condition: eligible byte, matching number, usable configuration.
    assign fire = eligible && (cur_idx == cfg_byte_idx) && cfg_ok;

    // Output registers: address, strobe and configuration flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_addr     <= '0;
            sp_addr_vld <= 1'b0;
            cfg_bad     <= 1'b0;
        end else begin
            sp_addr_vld <= fire;
            cfg_bad     <= !cfg_ok;
            if (fire) sp_addr <= gathered;
        end
    end
endmodule

// File: rtl/subport_addr_extract_chk.sv
// Module: subport_addr_extract_chk
// Property checks on the extractor's ports, attached by bind.
// Assumes: reset is asserted from time zero.
module subport_addr_extract_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_vld,
    input logic [7:0] in_byte,
    input logic [4:0] cfg_byte_idx,
    input logic [7:0] cfg_pos_mask,
    input logic [2:0] sp_addr,
    input logic       sp_addr_vld,
    input logic       cfg_bad
);
    // R3
    strobe_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_addr_vld |-> $past(in_vld));

    // R6
    strobe_needs_good_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_addr_vld |-> !cfg_bad);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_addr_vld |-> $stable(sp_addr));

    // R4
    default_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_addr_vld && $past(cfg_pos_mask) == 8'h07) |-> sp_addr == $past(in_byte[2:0]));

    // R5
    bad_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |-> ($past($countones(cfg_pos_mask)) != 3 || $past(cfg_byte_idx) >= 5'd18));
endmodule

bind subport_addr_extract subport_addr_extract_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_vld       (in_vld),
    .in_byte      (in_byte),
    .cfg_byte_idx (cfg_byte_idx),
    .cfg_pos_mask (cfg_pos_mask),
    .sp_addr      (sp_addr),
    .sp_addr_vld  (sp_addr_vld),
    .cfg_bad      (cfg_bad)
);

// File: tb/subport_addr_extract_tb_top.sv
// Bench for subport_addr_extract: directed corner cases plus seeded random
// headers, checked against a bench-side model of the requirements.
module subport_addr_extract_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic       hdr_sof = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [4:0] cfg_byte_idx = 5'd0;
    logic [7:0] cfg_pos_mask = 8'h07;
    logic [2:0] sp_addr;
    logic       sp_addr_vld;
    logic       cfg_bad;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    // Bench model state
    bit       m_open = 1'b0;
    bit       m_done = 1'b0;
    int       m_cnt  = 0;
    bit [2:0] m_addr = 3'd0;
    bit       e_vld  = 1'b0;
    bit       e_bad  = 1'b0;

    always #5 clk = ~clk;

    subport_addr_extract dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_vld       (in_vld),
        .hdr_sof      (hdr_sof),
        .in_byte      (in_byte),
        .cfg_byte_idx (cfg_byte_idx),
        .cfg_pos_mask (cfg_pos_mask),
        .sp_addr      (sp_addr),
        .sp_addr_vld  (sp_addr_vld),
        .cfg_bad      (cfg_bad)
    );

    // Gather marked bits, scanning from the top: first found becomes MSB.
    function automatic bit [2:0] ref_gather(input bit [7:0] d, input bit [7:0] m);
        bit [7:0] acc;
        acc = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            if (m[i]) acc = {acc[6:0], d[i]};
        end
        return acc[2:0];
    endfunction

    function automatic bit ref_cfg_ok(input bit [4:0] s, input bit [7:0] m);
        return ($countones(m) == 3) && (s < 5'd18);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, update the model, sample after the edge.
    task automatic step(input bit vld, input bit sof, input bit [7:0] d, input string req);
        int  idx;
        bit  fire;
        bit  served;
        @(negedge clk);
        in_vld  = vld;
        hdr_sof = sof;
        in_byte = d;
        fire    = 1'b0;
        if (vld) begin
            idx    = sof ? 0 : m_cnt;
            served = sof ? 1'b0 : m_done;
            fire   = (sof || m_open) && !served && (idx == int'(cfg_byte_idx)) &&
                     ref_cfg_ok(cfg_byte_idx, cfg_pos_mask);
            if (fire) m_addr = ref_gather(d, cfg_pos_mask);
            if (sof) m_open = 1'b1;
            m_done = fire || served;
            m_cnt  = (idx + 1 > 18) ? 18 : idx + 1;
        end
        e_vld = fire;
        e_bad = !ref_cfg_ok(cfg_byte_idx, cfg_pos_mask);
        @(posedge clk);
        #1;
        check(req, "sp_addr_vld", int'(sp_addr_vld), int'(e_vld));
        check(e_vld ? req : "R8", "sp_addr", int'(sp_addr), int'(m_addr));
        check("R5", "cfg_bad", int'(cfg_bad), int'(e_bad));
    endtask

    // Send one header of n bytes, byte k carrying data from dat[k].
    task automatic send_hdr(input int n, input bit [7:0] dat[20], input string req);
        for (int k = 0; k < n; k++) step(1'b1, k == 0, dat[k], req);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit [7:0] dat[20];
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "sp_addr in reset", int'(sp_addr), 0);
        check("R1", "sp_addr_vld in reset", int'(sp_addr_vld), 0);
        check("R1", "cfg_bad in reset", int'(cfg_bad), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "sp_addr after reset", int'(sp_addr), 0);
        check("R1", "sp_addr_vld after reset", int'(sp_addr_vld), 0);

        // R9: bytes before any header start are ignored
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 8'hFF, "R9");

        // R4: default mask, byte 0
        for (int k = 0; k < 20; k++) dat[k] = 8'(8'h10 + k);
        dat[0] = 8'hA5;
        send_hdr(3, dat, "R4");

        // R4: scattered mask 6,4,1 on byte 2 -> 0x50 gives 3'b110
        cfg_pos_mask = 8'b0101_0010;
        cfg_byte_idx = 5'd2;
        dat[2] = 8'h50;
        send_hdr(4, dat, "R4");

        // R2/R10: idle gaps and a bare start strobe do not disturb numbering
        cfg_pos_mask = 8'hE0;
        cfg_byte_idx = 5'd3;
        step(1'b1, 1'b1, 8'h00, "R2");
        step(1'b0, 1'b0, 8'hFF, "R2");
        step(1'b1, 1'b0, 8'h11, "R2");
        step(1'b0, 1'b1, 8'hFF, "R10");
        step(1'b1, 1'b0, 8'h22, "R10");
        step(1'b1, 1'b0, 8'hC0, "R2");
        step(1'b1, 1'b0, 8'hE0, "R3");

        // R3: last legal byte, index 17, fires once
        cfg_pos_mask = 8'h07;
        cfg_byte_idx = 5'd17;
        for (int k = 0; k < 20; k++) dat[k] = 8'(k);
        dat[17] = 8'h05;
        send_hdr(20, dat, "R3");

        // R7: header restarts before byte 17 arrives
        send_hdr(10, dat, "R7");
        send_hdr(18, dat, "R7");

        // R5/R6: index 18 is unusable
        cfg_byte_idx = 5'd18;
        send_hdr(20, dat, "R6");
        // R5/R6: four mask bits set
        cfg_byte_idx = 5'd1;
        cfg_pos_mask = 8'h0F;
        send_hdr(3, dat, "R6");
        // R5: no mask bits set
        cfg_pos_mask = 8'h00;
        send_hdr(3, dat, "R6");

        // Random headers
        for (int h = 0; h < 600; h++) begin
            int n;
            bit [7:0] m;
            if (($urandom % 8) != 0) begin
                do m = 8'($urandom); while ($countones(m) != 3);
                cfg_pos_mask = m;
                cfg_byte_idx = 5'($urandom % 18);
            end else begin
                cfg_pos_mask = 8'($urandom);
                cfg_byte_idx = 5'($urandom);
            end
            n = 1 + int'($urandom % 20);
            for (int k = 0; k < n; k++) begin
                if (($urandom % 6) == 0) step(1'b0, 1'($urandom), 8'($urandom), "R10");
                step(1'b1, k == 0, 8'($urandom), "R3");
            end
        end
        finish_run();
    end
endmodule